// File: doc/BRIEF.md
# Pulsed Readout Phase Sequencer

This block steps one front-end chip through each cycle of a pulsed beam. The chip sits in idle until a train-start strobe arrives. It then records events for a fixed acquisition window and asks the converter to digitise them. Once the converter reports completion, the chip waits for the readout token. While it holds the token, it shifts its stored events onto a serial line that many chips share, passes the token on and drops back to idle. The block drives one power enable for each analog stage. A stage that is marked as pulsed is switched on only in the phases that need it. A stage that is not pulsed stays on at all times.

Events come in on a valid/ready stream during acquisition. An event is taken only on a cycle where valid and ready are both high. Ready is low outside acquisition, when the local store is full, and on any cycle where a force trigger is present. The serial output is a one-bit valid/ready stream. A bit is consumed only when valid and ready are both high, and the data bit holds steady while ready is low.

Top module: `pp_seq`

## Requirements
- R1: While reset is asserted and just after it is released, the phase is idle (code 0), and the converter start, token output, serial valid, serial output enable, serial data and event ready are all low. The power enables equal the inverse of the pulse-enable mask.
- R2: Phase codes are idle=0, acquisition=1, conversion=2 and readout=3, and they only ever advance 0→1→2→3→0. A train-start sampled in idle gives acquisition on the next cycle. Acquisition lasts exactly ACQ_LEN cycles and then conversion follows. Train-start is ignored in every other phase.
- R3: The converter start is a one-cycle pulse in the first conversion cycle. A converter-done sampled in conversion gives readout on the next cycle. Converter-done in any other phase has no effect.
- R4: Power enable bit i is high when pulse-enable bit i is 0, or when the phase mask has bit i set. The default masks are acquisition 5'b00111, conversion 5'b01010, readout 5'b10000 and idle all zero.
- R5: Event ready is high only in acquisition with fewer than DEPTH events stored. Events are stored in the order they are accepted.
- R6: A force trigger in acquisition stores the word {1, cycle index within acquisition, where the first cycle is 0}. It takes priority over a stream event in the same cycle, so event ready is low. Stream events are stored as {0, data}. When the store is full, a force trigger stores nothing.
- R7: The token input is honoured only in readout while no transfer is in progress. In any other case it has no effect.
- R8: Stored words go out in store order. Each word is DW+1 bits long, most significant bit first. A bit advances only on a cycle where valid and ready are both high.
- R9: The serial output enable equals serial valid, and the serial data is 0 whenever the enable is low.
- R10: The token output is a one-cycle pulse in the cycle after the last bit is accepted. The phase is idle on the cycle after that, and the store is empty.
- R11: A chip with no stored events raises the token output in the cycle after it samples the token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| train_start_i | input | 1 | Start of a beam train |
| force_trig_i | input | 1 | External force trigger |
| evt_vld_i | input | 1 | Event stream valid |
| evt_rdy_o | output | 1 | Event stream ready |
| evt_dat_i | input | DW | Event payload |
| adc_start_o | output | 1 | Converter start pulse |
| adc_done_i | input | 1 | Converter finished |
| token_i | input | 1 | Token from the previous chip |
| token_o | output | 1 | Token to the next chip |
| ser_vld_o | output | 1 | Serial bit valid |
| ser_rdy_i | input | 1 | Serial bit ready |
| ser_dat_o | output | 1 | Serial data bit |
| ser_oe_o | output | 1 | Output enable for the shared line |
| pulse_en_i | input | NSTAGE | 1 = the stage follows the phase mask |
| pwr_en_o | output | NSTAGE | Per-stage power enables |
| phase_o | output | 2 | Current phase code |

## Verification
Every phase move, converter start and token output appears exactly one cycle after the edge that samples its cause. Power enables, event ready and the serial outputs follow the phase and serializer state in the same cycle. The bench drives its inputs just after a rising edge and samples all outputs at the next falling edge, so each check lands in the cycle in which the result is due. A scoreboard holds the expected words in acceptance order. The monitor rebuilds each word from the bits that were accepted on valid and ready, and compares it under a random ready pattern.

// File: rtl/pp_seq_pkg.sv
package pp_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ACQ  = 2'd1,
    PH_CONV = 2'd2,
    PH_READ = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_SHIFT = 2'd1,
    TX_PASS  = 2'd2
  } tx_e;
endpackage

// File: rtl/pp_phase_ctl.sv
module pp_phase_ctl
  import pp_seq_pkg::*;
#(
  parameter int ACQ_LEN = 32,
  localparam int CW = (ACQ_LEN > 1) ? $clog2(ACQ_LEN) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          train_start_i,
  input  logic          adc_done_i,
  input  logic          tx_done_i,
  output phase_e        phase_o,
  output logic [CW-1:0] acq_cnt_o,
  output logic          adc_start_o
);
  phase_e        phase_q;
  logic [CW-1:0] cnt_q;
  logic          start_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (train_start_i) begin
            phase_q <= PH_ACQ;
            cnt_q   <= '0;
          end
        end
        PH_ACQ: begin
          if (cnt_q == CW'(ACQ_LEN - 1)) begin
            phase_q <= PH_CONV;
            start_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_CONV: begin
          if (adc_done_i) phase_q <= PH_READ;
        end
        PH_READ: begin
          if (tx_done_i) phase_q <= PH_IDLE;
        end
      endcase
    end
  end

  assign phase_o     = phase_q;
  assign acq_cnt_o   = cnt_q;
  assign adc_start_o = start_q;
endmodule

// File: rtl/pp_evt_store.sv
module pp_evt_store #(
  parameter int EW    = 9,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [EW-1:0]   wr_dat_i,
  input  logic            clr_i,
  input  logic [AW-1:0]   rd_addr_i,
  output logic [EW-1:0]   rd_dat_o,
  output logic [CNTW-1:0] count_o,
  output logic            full_o
);
  logic [EW-1:0]   mem [DEPTH];
  logic [CNTW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (wr_en_i && !full_o) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i && !full_o) mem[cnt_q[AW-1:0]] <= wr_dat_i;
  end

  assign rd_dat_o = mem[rd_addr_i];
  assign count_o  = cnt_q;
  assign full_o   = (cnt_q == CNTW'(DEPTH));
endmodule

// File: rtl/pp_ser_tx.sv
module pp_ser_tx
  import pp_seq_pkg::*;
#(
  parameter int EW    = 9,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNTW = $clog2(DEPTH + 1),
  localparam int BW   = (EW > 1) ? $clog2(EW) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            grant_i,
  input  logic [CNTW-1:0] evt_cnt_i,
  input  logic [EW-1:0]   rd_dat_i,
  output logic [AW-1:0]   rd_addr_o,
  input  logic            ser_rdy_i,
  output logic            ser_vld_o,
  output logic            ser_dat_o,
  output logic            ser_oe_o,
  output logic            token_o,
  output logic            busy_o,
  output logic            done_o
);
  tx_e             st_q;
  logic [EW-1:0]   sh_q;
  logic [BW-1:0]   bit_q;
  logic [CNTW-1:0] ptr_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      st_q  <= TX_IDLE;
      sh_q  <= '0;
      bit_q <= '0;
      ptr_q <= '0;
    end else begin
      unique case (st_q)
        TX_IDLE: begin
          if (grant_i) begin
            if (evt_cnt_i == '0) begin
              st_q <= TX_PASS;
            end else begin
              sh_q  <= rd_dat_i;
              ptr_q <= ptr_q + 1'b1;
              bit_q <= '0;
              st_q  <= TX_SHIFT;
            end
          end
        end
        TX_SHIFT: begin
          if (ser_rdy_i) begin
            if (bit_q == BW'(EW - 1)) begin
              if (ptr_q == evt_cnt_i) begin
                st_q <= TX_PASS;
              end else begin
                sh_q  <= rd_dat_i;
                ptr_q <= ptr_q + 1'b1;
                bit_q <= '0;
              end
            end else begin
              sh_q  <= {sh_q[EW-2:0], 1'b0};
              bit_q <= bit_q + 1'b1;
            end
          end
        end
        TX_PASS: begin
          st_q  <= TX_IDLE;
          ptr_q <= '0;
        end
        default: st_q <= TX_IDLE;
      endcase
    end
  end

  assign rd_addr_o = ptr_q[AW-1:0];
  assign ser_vld_o = (st_q == TX_SHIFT);
  assign ser_oe_o  = (st_q == TX_SHIFT);
  assign ser_dat_o = (st_q == TX_SHIFT) && sh_q[EW-1];
  assign token_o   = (st_q == TX_PASS);
  assign done_o    = (st_q == TX_PASS);
  assign busy_o    = (st_q != TX_IDLE);
endmodule

// File: rtl/pp_pwr_map.sv
module pp_pwr_map
  import pp_seq_pkg::*;
#(
  parameter int                NSTAGE    = 5,
  parameter logic [NSTAGE-1:0] MASK_ACQ  = '0,
  parameter logic [NSTAGE-1:0] MASK_CONV = '0,
  parameter logic [NSTAGE-1:0] MASK_READ = '0
) (
  input  phase_e            phase_i,
  input  logic [NSTAGE-1:0] pulse_en_i,
  output logic [NSTAGE-1:0] pwr_en_o
);
  for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
    logic need;
    always_comb begin
      unique case (phase_i)
        PH_ACQ:  need = MASK_ACQ[g];
        PH_CONV: need = MASK_CONV[g];
        PH_READ: need = MASK_READ[g];
        default: need = 1'b0;
      endcase
    end
    assign pwr_en_o[g] = !pulse_en_i[g] || need;
  end
endmodule

// File: rtl/pp_seq.sv
module pp_seq
  import pp_seq_pkg::*;
#(
  parameter int                DW        = 8,
  parameter int                DEPTH     = 8,
  parameter int                ACQ_LEN   = 32,
  parameter int                NSTAGE    = 5,
  parameter logic [NSTAGE-1:0] MASK_ACQ  = 5'b00111,
  parameter logic [NSTAGE-1:0] MASK_CONV = 5'b01010,
  parameter logic [NSTAGE-1:0] MASK_READ = 5'b10000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              train_start_i,
  input  logic              force_trig_i,
  input  logic              evt_vld_i,
  output logic              evt_rdy_o,
  input  logic [DW-1:0]     evt_dat_i,
  output logic              adc_start_o,
  input  logic              adc_done_i,
  input  logic              token_i,
  output logic              token_o,
  output logic              ser_vld_o,
  input  logic              ser_rdy_i,
  output logic              ser_dat_o,
  output logic              ser_oe_o,
  input  logic [NSTAGE-1:0] pulse_en_i,
  output logic [NSTAGE-1:0] pwr_en_o,
  output logic [1:0]        phase_o
);
  localparam int EW   = DW + 1;
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam int CW   = (ACQ_LEN > 1) ? $clog2(ACQ_LEN) : 1;

  phase_e          phase;
  logic [CW-1:0]   acq_cnt;
  logic            tx_done, tx_busy, grant;
  logic            full, wr_en, in_acq;
  logic [EW-1:0]   wr_dat, rd_dat;
  logic [AW-1:0]   rd_addr;
  logic [CNTW-1:0] evt_cnt;
  logic [DW-1:0]   stamp;

  pp_phase_ctl #(.ACQ_LEN(ACQ_LEN)) u_phase (
    .clk_i, .rst_ni, .train_start_i, .adc_done_i,
    .tx_done_i(tx_done), .phase_o(phase), .acq_cnt_o(acq_cnt),
    .adc_start_o
  );

  assign in_acq    = (phase == PH_ACQ);
  assign stamp     = DW'(acq_cnt);
  assign evt_rdy_o = in_acq && !full && !force_trig_i;
  assign wr_en     = in_acq && !full && (force_trig_i || evt_vld_i);
  assign wr_dat    = force_trig_i ? {1'b1, stamp} : {1'b0, evt_dat_i};

  pp_evt_store #(.EW(EW), .DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_dat_i(wr_dat), .clr_i(tx_done),
    .rd_addr_i(rd_addr), .rd_dat_o(rd_dat), .count_o(evt_cnt), .full_o(full)
  );

  assign grant = (phase == PH_READ) && token_i && !tx_busy;

  pp_ser_tx #(.EW(EW), .DEPTH(DEPTH)) u_tx (
    .clk_i, .rst_ni, .grant_i(grant), .evt_cnt_i(evt_cnt), .rd_dat_i(rd_dat),
    .rd_addr_o(rd_addr), .ser_rdy_i, .ser_vld_o, .ser_dat_o, .ser_oe_o,
    .token_o, .busy_o(tx_busy), .done_o(tx_done)
  );

  pp_pwr_map #(
    .NSTAGE(NSTAGE), .MASK_ACQ(MASK_ACQ), .MASK_CONV(MASK_CONV), .MASK_READ(MASK_READ)
  ) u_pwr (
    .phase_i(phase), .pulse_en_i, .pwr_en_o
  );

  assign phase_o = phase;
endmodule

// File: rtl/pp_seq_chk.sv
module pp_seq_chk #(
  parameter int DW     = 8,
  parameter int NSTAGE = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              train_start_i,
  input logic              force_trig_i,
  input logic              evt_vld_i,
  input logic              evt_rdy_o,
  input logic [DW-1:0]     evt_dat_i,
  input logic              adc_start_o,
  input logic              adc_done_i,
  input logic              token_i,
  input logic              token_o,
  input logic              ser_vld_o,
  input logic              ser_rdy_i,
  input logic              ser_dat_o,
  input logic              ser_oe_o,
  input logic [NSTAGE-1:0] pulse_en_i,
  input logic [NSTAGE-1:0] pwr_en_o,
  input logic [1:0]        phase_o
);
  a_r2_phase_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o != $past(phase_o)) |-> (phase_o == $past(phase_o) + 2'd1));

  a_r3_start_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_o |=> !adc_start_o);

  a_r3_start_in_conv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_o |-> (phase_o == 2'd2));

  a_r4_idle_power: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 2'd0) |-> (pwr_en_o == ~pulse_en_i));

  a_r5_rdy_in_acq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_rdy_o |-> (phase_o == 2'd1));

  a_r6_force_prio: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_trig_i |-> !evt_rdy_o);

  a_r7_token_outside: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (token_i && phase_o != 2'd3) |=> (!ser_oe_o && !token_o));

  a_r8_hold_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_vld_o && !ser_rdy_i) |=> (ser_vld_o && $stable(ser_dat_o)));

  a_r9_quiet_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ser_oe_o |-> (!ser_vld_o && !ser_dat_o));

  a_r10_token_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    token_o |=> !token_o);

  a_r10_idle_after: assert property (@(posedge clk_i) disable iff (!rst_ni)
    token_o |=> (phase_o == 2'd0));
endmodule

bind pp_seq pp_seq_chk #(.DW(DW), .NSTAGE(NSTAGE)) u_chk (.*);

// File: tb/pp_seq_tb_top.sv
module pp_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8, DEPTH = 8, ACQ_LEN = 32, NSTAGE = 5, EW = DW + 1;
  localparam logic [NSTAGE-1:0] M_ACQ = 5'b00111, M_CONV = 5'b01010, M_READ = 5'b10000;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic rst_n, train_start, force_trig, evt_vld, evt_rdy, adc_start, adc_done;
  logic token_in, token_out, ser_vld, ser_rdy, ser_dat, ser_oe;
  logic [DW-1:0] evt_dat;
  logic [NSTAGE-1:0] pulse_en, pwr_en;
  logic [1:0] phase;
  logic rdy_rand = 1'b0;

  pp_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .train_start_i(train_start), .force_trig_i(force_trig),
    .evt_vld_i(evt_vld), .evt_rdy_o(evt_rdy), .evt_dat_i(evt_dat),
    .adc_start_o(adc_start), .adc_done_i(adc_done), .token_i(token_in), .token_o(token_out),
    .ser_vld_o(ser_vld), .ser_rdy_i(ser_rdy), .ser_dat_o(ser_dat), .ser_oe_o(ser_oe),
    .pulse_en_i(pulse_en), .pwr_en_o(pwr_en), .phase_o(phase)
  );

  int checks = 0, errors = 0, words_rx = 0;
  logic [EW-1:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // serial ready pattern
  initial begin
    logic [7:0] l = 8'h5A;
    ser_rdy = 1'b1;
    forever begin
      @(posedge clk); #1;
      l = {l[6:0], l[7] ^ l[5] ^ l[4] ^ l[3]};
      ser_rdy = rdy_rand ? l[0] : 1'b1;
    end
  end

  // monitor: rebuild words, compare against scoreboard
  initial begin
    logic [EW-1:0] acc = '0;
    int nb = 0;
    logic hold_v = 1'b0, hold_d = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (ser_oe || ser_vld)
          chk(ser_oe == ser_vld && (ser_oe || !ser_dat), "R9 enable vs valid", ser_oe, ser_vld);
        if (hold_v) chk(ser_vld && ser_dat == hold_d, "R8 bit held under back-pressure", ser_dat, hold_d);
        hold_v = ser_vld && !ser_rdy;
        hold_d = ser_dat;
        if (ser_vld && ser_rdy) begin
          acc = {acc[EW-2:0], ser_dat};
          nb++;
          if (nb == EW) begin
            nb = 0;
            words_rx++;
            if (exp_q.size() == 0) chk(1'b0, "R8 unexpected word", int'(acc), 0);
            else begin
              logic [EW-1:0] e;
              e = exp_q.pop_front();
              chk(acc == e, "R6/R8 serial word", int'(acc), int'(e));
            end
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=completion");
    finish_run();
  end

  task automatic run_to_read();
    // conversion through readout entry
    @(negedge clk);
    chk(phase == 2'd2, "R2 conversion after acquisition", phase, 2);
    chk(adc_start == 1'b1, "R3 start pulse in first conversion cycle", adc_start, 1);
    chk(pwr_en == (M_CONV | ~pulse_en), "R4 conversion power", pwr_en, M_CONV | ~pulse_en);
    step();
    @(negedge clk);
    chk(adc_start == 1'b0, "R3 start is single-cycle", adc_start, 0);
    adc_done = 1'b1; step(); adc_done = 1'b0;
    @(negedge clk);
    chk(phase == 2'd3, "R3 done moves to readout", phase, 3);
    chk(pwr_en == (M_READ | ~pulse_en), "R4 readout power", pwr_en, M_READ | ~pulse_en);
  endtask

  initial begin
    int n = 0;
    rst_n = 1'b0; train_start = 0; force_trig = 0; evt_vld = 0; evt_dat = '0;
    adc_done = 0; token_in = 0; pulse_en = '1;
    repeat (3) step();
    @(negedge clk);
    chk(phase == 2'd0 && !adc_start && !token_out && !ser_vld && !ser_oe && !ser_dat && !evt_rdy,
        "R1 outputs in reset", phase, 0);
    chk(pwr_en == '0, "R1 power in reset", pwr_en, 0);
    step(); rst_n = 1'b1;
    @(negedge clk);
    chk(phase == 2'd0 && !evt_rdy, "R1 idle after reset", phase, 0);

    // idle: inputs that must be ignored
    evt_vld = 1'b1; adc_done = 1'b1; token_in = 1'b1;
    @(negedge clk);
    chk(evt_rdy == 1'b0, "R5 no ready in idle", evt_rdy, 0);
    step(); evt_vld = 0; adc_done = 0; token_in = 0;
    @(negedge clk);
    chk(phase == 2'd0, "R3 done ignored in idle", phase, 0);
    chk(token_out == 1'b0 && ser_oe == 1'b0, "R7 token ignored in idle", token_out, 0);

    // first train
    train_start = 1'b1; step(); train_start = 1'b0;
    for (int k = 0; k < ACQ_LEN; k++) begin
      force_trig = (k == 3) || (k == 4) || (k == 12);
      evt_vld    = (k == 2) || (k == 4) || (k >= 5 && k <= 10);
      evt_dat    = DW'(8'hA0 + k);
      token_in   = (k == 15);
      @(negedge clk);
      chk(phase == 2'd1, "R2 acquisition lasts ACQ_LEN cycles", phase, 1);
      if (k == 0) chk(pwr_en == M_ACQ, "R4 acquisition power", pwr_en, M_ACQ);
      chk(evt_rdy == (!force_trig && n < DEPTH), "R5/R6 event ready", evt_rdy, !force_trig && n < DEPTH);
      if (force_trig && n < DEPTH) begin
        exp_q.push_back({1'b1, DW'(k)}); n++;       // R6 forced word
      end else if (evt_vld && evt_rdy) begin
        exp_q.push_back({1'b0, evt_dat}); n++;      // R5 stored in order
      end
      step();
    end
    force_trig = 0; evt_vld = 0; token_in = 0;
    chk(n == DEPTH, "R5 store filled to depth", n, DEPTH);
    run_to_read();

    // readout: wait without token, stray train-start ignored
    train_start = 1'b1; step(); train_start = 1'b0;
    repeat (4) step();
    @(negedge clk);
    chk(phase == 2'd3, "R2 train-start ignored in readout", phase, 3);
    chk(ser_oe == 1'b0 && ser_vld == 1'b0, "R7 early token ignored", ser_oe, 0);

    rdy_rand = 1'b1;
    token_in = 1'b1; step(); token_in = 1'b0;
    begin
      int t = 0;
      @(negedge clk);
      while (!token_out && t < 1000) begin @(negedge clk); t++; end
      chk(token_out == 1'b1, "R10 token passed after transfer", token_out, 1);
    end
    chk(exp_q.size() == 0 && words_rx == DEPTH, "R8 all words sent", words_rx, DEPTH);
    @(negedge clk);
    chk(token_out == 1'b0, "R10 token is single-cycle", token_out, 0);
    chk(phase == 2'd0, "R10 idle after token", phase, 0);
    rdy_rand = 1'b0;

    // second train, empty store, stage 1 not pulsed
    pulse_en = 5'b11101;
    @(negedge clk);
    chk(pwr_en == 5'b00010, "R4 unpulsed stage stays on", pwr_en, 5'b00010);
    train_start = 1'b1; step(); train_start = 1'b0;
    @(negedge clk);
    chk(pwr_en == (M_ACQ | 5'b00010), "R4 acquisition with unpulsed stage", pwr_en, M_ACQ | 5'b00010);
    repeat (ACQ_LEN) step();
    run_to_read();
    token_in = 1'b1; step(); token_in = 1'b0;
    @(negedge clk);
    chk(token_out == 1'b1, "R11 empty chip passes token next cycle", token_out, 1);
    chk(ser_oe == 1'b0, "R9 line quiet when empty", ser_oe, 0);
    @(negedge clk);
    chk(phase == 2'd0 && !token_out, "R10 idle after empty pass", phase, 0);
    chk(words_rx == DEPTH, "R8 no extra words", words_rx, DEPTH);

    finish_run();
  end
endmodule